// File: doc/BRIEF.md
# Pipelined Bitonic Sorting Network

This block orders a vector of N unsigned words, N = 8 by default and always a power of two, through a fixed comparator network. The comparisons do not depend on the data. Each clock cycle, the caller presents one vector together with a valid flag and an order bit. The order bit selects largest-first when it is 1 and smallest-first when it is 0. The vector travels through p(p+1)/2 compare-exchange stages, where p = log2(N). A register follows each stage, so a fully ordered vector leaves the block a fixed number of cycles later with its own valid flag.

The stage schedule comes from unfolding a recursive scheme. In phase k, for k = 1..p, the block runs k stages with comparison distances 2^(k-1) down to 1. In each stage, a cell joins wire i and wire i XOR 2^m. Bit k of the lower index sets the cell's base sense: 0 means smaller value to the lower wire, and 1 means the reverse. The earlier phases therefore build bitonic runs, and the last phase merges them. When the order bit is set, every cell's sense is flipped. The order bit moves down the pipeline with its own vector.

The input side has no ready signal, so it applies no back-pressure. A vector whose valid flag is high is always taken. The downstream logic must accept one result per cycle. Callers with fewer than N items must pad the vector themselves.

Top module: `bitonic_sorter`

## Requirements
- R1: With the order bit at 0, the output words are non-decreasing from word 0 (bits W-1:0) up to word N-1.
- R2: With the order bit at 1, the output words are non-increasing from word 0 up to word N-1.
- R3: A vector presented with in_valid high appears on out_data with out_valid high exactly p(p+1)/2 cycles later (6 for N = 8). Cycles with in_valid low produce cycles with out_valid low at the same distance.
- R4: A new vector is accepted on every cycle, including back-to-back vectors that request different orders. Each vector is ordered by its own order bit.
- R5: The output vector is a permutation of the input vector, so every word, including repeats, survives.
- R6: A synchronous active-high reset drops every vector still in flight. out_valid is low in the cycle after any reset cycle and stays low until new valid input has had time to pass through.
- R7: Equal words are never exchanged. Inputs with many repeats, such as vectors built only from 0 and all-ones, are still ordered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the valid pipeline |
| in_valid | input | 1 | in_data holds a vector this cycle |
| in_desc | input | 1 | Order request: 0 smallest-first, 1 largest-first |
| in_data | input | N*W | Input vector, word i at bits i*W +: W |
| out_valid | output | 1 | out_data holds an ordered vector |
| out_data | output | N*W | Ordered vector, same packing as in_data |

## Verification
The bench runs every permutation of eight distinct words. A cell with the wrong sense or partner would leave at least one of these permutations misordered. The bench also runs all 256 zero/all-ones patterns in both orders, which brings out any mistake in swapping equal words or in the phase schedule. It changes the order bit from one vector to the next, so an order bit that slips a stage against its data orders some vector the wrong way. Randomly spaced valid gaps and a reset in the middle of a stream catch an off-by-one latency and valid flags that outlive a reset.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

  // Number of register stages for a network of 2**p wires.
  function automatic int stage_count(input int p);
    return (p * (p + 1)) / 2;
  endfunction

  // Base sense of the cell whose lower wire is idx in phase ph:
  // 1 = smaller word to the lower wire.
  function automatic bit cell_up(input int idx, input int ph);
    return ((idx >> ph) & 1) == 0;
  endfunction

endpackage

// File: rtl/bsort_cmpx.sv
module bsort_cmpx #(
  parameter int W = 16
) (
  input  logic         up,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic swap;

  // Strict comparison: equal words stay on their own wires.
  always_comb begin
    swap = up ? (a > b) : (a < b);
    lo   = swap ? b : a;
    hi   = swap ? a : b;
  end
endmodule

// File: rtl/bsort_stage.sv
module bsort_stage #(
  parameter int N     = 8,
  parameter int W     = 16,
  parameter int PHASE = 1,
  parameter int DLOG  = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           in_desc,
  input  logic [N*W-1:0] in_data,
  output logic           out_valid,
  output logic           out_desc,
  output logic [N*W-1:0] out_data
);
  localparam int DIST = 1 << DLOG;

  logic [W-1:0] cur [N];
  logic [W-1:0] nxt [N];
  logic [N*W-1:0] nxt_flat;

  for (genvar i = 0; i < N; i++) begin : g_wire
    assign cur[i] = in_data[i*W +: W];
    assign nxt_flat[i*W +: W] = nxt[i];
    if (((i >> DLOG) & 1) == 0) begin : g_cell
      logic up_i;
      assign up_i = bsort_pkg::cell_up(i, PHASE) ^ in_desc;
      bsort_cmpx #(.W(W)) u_cell (
        .up (up_i),
        .a  (cur[i]),
        .b  (cur[i+DIST]),
        .lo (nxt[i]),
        .hi (nxt[i+DIST])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  // Data and order bit carry no reset.
  always_ff @(posedge clk) begin
    out_data <= nxt_flat;
    out_desc <= in_desc;
  end
endmodule

// File: rtl/bitonic_sorter.sv
module bitonic_sorter #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           in_desc,
  input  logic [N*W-1:0] in_data,
  output logic           out_valid,
  output logic [N*W-1:0] out_data
);
  localparam int P    = $clog2(N);
  localparam int NSTG = bsort_pkg::stage_count(P);

  logic [N*W-1:0] pd [NSTG+1];
  logic           pv [NSTG+1];
  logic           ps [NSTG+1];

  assign pd[0] = in_data;
  assign pv[0] = in_valid;
  assign ps[0] = in_desc;

  for (genvar k = 1; k <= P; k++) begin : g_phase
    for (genvar t = 0; t < k; t++) begin : g_step
      localparam int IDX = (k * (k - 1)) / 2 + t;
      bsort_stage #(
        .N(N), .W(W), .PHASE(k), .DLOG(k - 1 - t)
      ) u_stg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (pv[IDX]),
        .in_desc   (ps[IDX]),
        .in_data   (pd[IDX]),
        .out_valid (pv[IDX+1]),
        .out_desc  (ps[IDX+1]),
        .out_data  (pd[IDX+1])
      );
    end
  end

  assign out_valid = pv[NSTG];
  assign out_data  = pd[NSTG];
endmodule

// File: rtl/bsort_chk.sv
module bsort_chk #(
  parameter int N = 8,
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_desc,
  input logic [N*W-1:0] in_data,
  input logic           out_valid,
  input logic [N*W-1:0] out_data
);
  localparam int P   = $clog2(N);
  localparam int LAT = bsort_pkg::stage_count(P);
  localparam int SW  = W + P;

  function automatic logic [SW-1:0] wsum(input logic [N*W-1:0] x);
    logic [SW-1:0] s;
    s = '0;
    for (int i = 0; i < N; i++) s = s + SW'(x[i*W +: W]);
    return s;
  endfunction

  function automatic bit ordered(input logic [N*W-1:0] x, input logic dsc);
    bit ok;
    ok = 1'b1;
    for (int i = 0; i + 1 < N; i++) begin
      if (!dsc && x[i*W +: W] > x[(i+1)*W +: W]) ok = 1'b0;
      if ( dsc && x[i*W +: W] < x[(i+1)*W +: W]) ok = 1'b0;
    end
    return ok;
  endfunction

  logic          vp [LAT];
  logic          dp [LAT];
  logic [SW-1:0] sp [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) vp[i] <= 1'b0;
    end else begin
      vp[0] <= in_valid;
      for (int i = 1; i < LAT; i++) vp[i] <= vp[i-1];
    end
  end

  always_ff @(posedge clk) begin
    dp[0] <= in_desc;
    sp[0] <= wsum(in_data);
    for (int i = 1; i < LAT; i++) begin
      dp[i] <= dp[i-1];
      sp[i] <= sp[i-1];
    end
  end

  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == vp[LAT-1]);

  a_r1_ascending: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !dp[LAT-1]) |-> ordered(out_data, 1'b0));

  a_r2_descending: assert property (@(posedge clk) disable iff (rst)
    (out_valid && dp[LAT-1]) |-> ordered(out_data, 1'b1));

  a_r5_sum_kept: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (wsum(out_data) == sp[LAT-1]));

  a_r6_reset_flush: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind bitonic_sorter bsort_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/bitonic_sorter_tb.sv
module bitonic_sorter_tb;
  localparam int N   = 8;
  localparam int W   = 8;
  localparam int LAT = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_desc = 1'b0;
  logic [N*W-1:0] in_data = '0;
  logic           out_valid;
  logic [N*W-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic           sh_v [LAT];
  logic [N*W-1:0] sh_d [LAT];
  string          sh_t [LAT];

  always #2.5 clk = ~clk;

  bitonic_sorter #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_desc(in_desc),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] x, input logic dsc);
    logic [W-1:0] a [N];
    logic [W-1:0] tmp;
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) a[i] = x[i*W +: W];
    for (int i = 0; i < N; i++)
      for (int j = 0; j + 1 < N - i; j++)
        if (dsc ? (a[j] < a[j+1]) : (a[j] > a[j+1])) begin
          tmp = a[j]; a[j] = a[j+1]; a[j+1] = tmp;
        end
    for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
    return r;
  endfunction

  function automatic logic [N*W-1:0] perm_vec(input int idx);
    int avail [N];
    int fact, rem, q, cnt;
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) avail[i] = 1;
    rem = idx;
    for (int pos = 0; pos < N; pos++) begin
      fact = 1;
      for (int f = 2; f <= N - 1 - pos; f++) fact = fact * f;
      q = rem / fact;
      rem = rem % fact;
      cnt = 0;
      for (int i = 0; i < N; i++) if (avail[i] == 1) begin
        if (cnt == q) begin
          avail[i] = 0;
          r[pos*W +: W] = W'(i * 29 + 3);
        end
        cnt++;
      end
    end
    return r;
  endfunction

  task automatic check_out();
    n_chk++;
    if (sh_v[LAT-1]) begin
      if (!(out_valid === 1'b1 && out_data === sh_d[LAT-1])) begin
        n_bad++;
        $display("FAIL %s: valid=%b data=%h expected valid=1 data=%h",
                 sh_t[LAT-1], out_valid, out_data, sh_d[LAT-1]);
      end
    end else if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: valid=%b expected valid=0", sh_t[LAT-1], out_valid);
    end
  endtask

  task automatic push(input logic v, input logic [N*W-1:0] e, input string t);
    for (int i = LAT - 1; i > 0; i--) begin
      sh_v[i] = sh_v[i-1]; sh_d[i] = sh_d[i-1]; sh_t[i] = sh_t[i-1];
    end
    sh_v[0] = v; sh_d[0] = e; sh_t[0] = t;
  endtask

  task automatic step(input logic v, input logic dsc, input logic [N*W-1:0] x, input string t);
    @(negedge clk);
    check_out();
    in_valid = v;
    in_desc  = dsc;
    in_data  = x;
    push(v, ref_sort(x, dsc), v ? t : "R3");
  endtask

  task automatic mid_reset();
    @(negedge clk);
    check_out();
    rst = 1'b1;
    in_valid = 1'b1;
    for (int i = 0; i < LAT; i++) begin
      sh_v[i] = 1'b0; sh_t[i] = "R6";
    end
    @(negedge clk);
    check_out();
    rst = 1'b0;
    in_valid = 1'b0;
    push(1'b0, '0, "R6");
  endtask

  initial begin
    logic [N*W-1:0] x;
    for (int i = 0; i < LAT; i++) begin
      sh_v[i] = 1'b0; sh_d[i] = '0; sh_t[i] = "R6";
    end
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R6: reset state valid=%b expected 0", out_valid);
    end
    rst = 1'b0;

    // Worked example, both orders (R1, R2)
    x = {8'd6, 8'd3, 8'd1, 8'd8, 8'd5, 8'd2, 8'd7, 8'd4};
    step(1'b1, 1'b0, x, "R1");
    step(1'b1, 1'b1, x, "R2");
    for (int i = 0; i < LAT; i++) step(1'b0, 1'b0, '0, "R3");

    // Every permutation, order bit changing between vectors (R4, R5)
    for (int n = 0; n < 40320; n++)
      step(1'b1, (n % 3) == 0, perm_vec(n), "R4");

    // Zero/all-ones patterns, many ties (R7)
    for (int b = 0; b < 512; b++) begin
      for (int i = 0; i < N; i++) x[i*W +: W] = b[i] ? {W{1'b1}} : '0;
      step(1'b1, b[8], x, "R7");
    end

    // Random repeats with valid gaps (R3, R5)
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < N; i++) x[i*W +: W] = W'($urandom % 5);
      step(($urandom % 3) != 0, $urandom % 2, x, "R5");
    end

    // Reset with vectors in flight (R6)
    for (int n = 0; n < 4; n++) step(1'b1, 1'b0, perm_vec(n * 97), "R1");
    mid_reset();
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 1'b0, '0, "R6");
    step(1'b1, 1'b1, perm_vec(777), "R2");
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 1'b0, '0, "R3");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule